// File: doc/BRIEF.md
# Byte FIFO pair with watermark and idle-data interrupts

This block sits between a host-side register interface and a serial shifter. It holds one byte queue for outgoing data, filled by the host and drained by the shifter. It holds a second byte queue for incoming data, filled by the shifter and drained by the host. Both sides use plain single-cycle push and pop strobes. A 32-bit control word switches each queue on or off and sets a 7-bit trigger level for each. The block has no register decoder: that word, the idle limit and the interrupt mask are level inputs that the surrounding register file drives.

A 12-bit sticky status vector collects the events. It flags a low transmit queue and a high receive queue. It flags a push into a full queue and a pop from an empty queue, on each side. It flags a "trailing data" condition: received bytes sit below the trigger level with no traffic for a programmed number of cycles. Five transfer-level events arrive from the shifter on separate strobes and are collected in the same vector. A status bit stays set until the host writes a 1 to it. A single interrupt line is the OR of the enabled status bits.

The trailing detector is a three-state machine. WAIT is the rest state. In WAIT a qualifying cycle moves it to COUNT, or to FIRED at once when the limit is zero. In COUNT a non-qualifying cycle returns it to WAIT. In COUNT a qualifying cycle in which the counter has reached the limit moves it to FIRED and raises the status bit. In FIRED the first non-qualifying cycle returns it to WAIT. A qualifying cycle is one in which the receive queue is enabled, its level is non-zero and below the trigger, and it sees neither a push nor a pop.

Top module: `fifo_irq_hub`

## Requirements
- R1: After reset both queues are empty, all status bits and `irq` are 0, `rd_data` outputs are 0, and `fifo_status` reads 0x0100_0100.
- R2: Each queue returns bytes in the order they were accepted. The popped byte appears on the matching `*_rd_data` output in the cycle after the pop edge and holds until the next successful pop.
- R3: In `fifo_status`, bits 6:0 hold the transmit level, bit 7 is transmit full and bit 8 is transmit empty. Bits 22:16 hold the receive level, bit 23 is receive full and bit 24 is receive empty. All other bits read 0.
- R4: A push into a full queue drops the byte and leaves the level at DEPTH. It sets status bit 3 on the transmit side and bit 5 on the receive side.
- R5: A pop from an empty queue leaves `*_rd_data` unchanged. It sets status bit 2 on the transmit side and bit 4 on the receive side.
- R6: `fifo_ctl` bit 0 enables the receive queue and bit 1 enables the transmit queue. A disabled queue is emptied at the next edge. Its pushes and pops are ignored and raise no status bit.
- R7: Status bit 0 is set at every edge where the transmit queue is enabled and its level is at or below `fifo_ctl[22:16]`.
- R8: Status bit 1 is set at every edge where the receive queue is enabled and its level is at or above `fifo_ctl[10:4]`.
- R9: Status bit 6 is set at the (N+1)th consecutive qualifying edge, where N is `trail_limit`. It is set once per idle stretch, and any receive push or pop starts a new stretch.
- R10: An edge with `sts_clr_en` high clears every status bit whose `sts_clr_mask` bit is 1. A bit that is set at the same edge stays 1. Writing back the value just read clears every pending bit.
- R11: `xfer_evt[k]` high at an edge sets status bit 7+k.
- R12: `irq` is 1 exactly when some status bit and the same bit of `irq_en` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_ctl | input | 32 | Queue enables and trigger levels |
| trail_limit | input | 4 | Idle-cycle limit for the trailing interrupt |
| irq_en | input | 12 | Per-bit interrupt enable |
| tx_wr_en | input | 1 | Host push into the transmit queue |
| tx_wr_data | input | 8 | Byte to push into the transmit queue |
| tx_rd_en | input | 1 | Shifter pop from the transmit queue |
| tx_rd_data | output | 8 | Last byte popped from the transmit queue |
| rx_wr_en | input | 1 | Shifter push into the receive queue |
| rx_wr_data | input | 8 | Byte to push into the receive queue |
| rx_rd_en | input | 1 | Host pop from the receive queue |
| rx_rd_data | output | 8 | Last byte popped from the receive queue |
| xfer_evt | input | 5 | Transfer events; bit k sets status bit 7+k |
| sts_clr_en | input | 1 | Write-1-to-clear strobe |
| sts_clr_mask | input | 12 | Bits to clear |
| irq_status | output | 12 | Sticky interrupt status |
| fifo_status | output | 32 | Levels and full/empty flags |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is the trailing interrupt. It needs a receive level strictly between zero and the trigger, and then an exact run of quiet edges with no push or pop at all. The stimulus spaces its receive pushes so that the detector is restarted between them. After the last push it counts edges one by one and checks that bit 6 is still clear one edge before the deadline and set at it. It then clears the bit and keeps the queue idle, to show that the same stretch raises no second interrupt. The clash between a clear and a still-true watermark is reached by clearing bit 0 while the transmit level is under its trigger.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

    localparam int STS_W   = 12;
    localparam int EVT_W   = 5;
    localparam int TRIG_W  = 7;
    localparam int LIMIT_W = 4;

    // status bit positions
    localparam int ST_TX_LOW   = 0;
    localparam int ST_RX_HIGH  = 1;
    localparam int ST_TX_UNDER = 2;
    localparam int ST_TX_OVER  = 3;
    localparam int ST_RX_UNDER = 4;
    localparam int ST_RX_OVER  = 5;
    localparam int ST_TRAIL    = 6;
    localparam int ST_EVT_LSB  = 7;

    // control word fields
    localparam int CTL_RX_ON     = 0;
    localparam int CTL_TX_ON     = 1;
    localparam int CTL_RX_TRIG_L = 4;
    localparam int CTL_TX_TRIG_L = 16;

    // status word fields
    localparam int FS_TX_LVL_L = 0;
    localparam int FS_TX_FULL  = 7;
    localparam int FS_TX_EMPTY = 8;
    localparam int FS_RX_LVL_L = 16;
    localparam int FS_RX_FULL  = 23;
    localparam int FS_RX_EMPTY = 24;

    typedef enum logic [1:0] {
        TR_WAIT  = 2'd0,
        TR_COUNT = 2'd1,
        TR_FIRED = 2'd2
    } trail_state_e;

endpackage

// File: rtl/byte_queue.sv
module byte_queue #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          overrun,
    output logic          underrun
);

    logic [DW-1:0] store [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] cnt;
    logic          do_push, do_pop;

    assign full     = (cnt == LW'(DEPTH));
    assign empty    = (cnt == '0);
    assign level    = cnt;
    assign do_push  = enable && push && !full;
    assign do_pop   = enable && pop && !empty;
    assign overrun  = enable && push && full;
    assign underrun = enable && pop && empty;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            cnt      <= '0;
            pop_data <= '0;
        end else if (!enable) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop) begin
                rd_ptr   <= step(rd_ptr);
                pop_data <= store[rd_ptr];
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R4
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LW'(DEPTH));
    // R4
    drop_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !pop) |=> (cnt == LW'(DEPTH)));
    // R5
    keep_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> $stable(pop_data));
    // R6
    flush_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt == '0));

endmodule

// File: rtl/trail_timer.sv
module trail_timer
    import fifo_irq_pkg::*;
#(
    parameter int LW = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [LW-1:0]      level,
    input  logic [TRIG_W-1:0]  trig,
    input  logic               activity,
    input  logic [LIMIT_W-1:0] limit,
    output logic               fire
);

    trail_state_e       state, state_nx;
    logic [LIMIT_W-1:0] cnt, cnt_nx;
    logic [7:0]         lvl_x, trig_x;
    logic               qual;

    assign lvl_x  = 8'(level);
    assign trig_x = 8'(trig);
    assign qual   = enable && (lvl_x != 8'd0) && (lvl_x < trig_x) && !activity;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TR_WAIT;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        fire     = 1'b0;
        unique case (state)
            TR_WAIT: begin
                cnt_nx = '0;
                if (qual) begin
                    if (limit == '0) begin
                        state_nx = TR_FIRED;
                        fire     = 1'b1;
                    end else begin
                        state_nx = TR_COUNT;
                        cnt_nx   = LIMIT_W'(1);
                    end
                end
            end
            TR_COUNT: begin
                if (!qual) begin
                    state_nx = TR_WAIT;
                    cnt_nx   = '0;
                end else if (cnt >= limit) begin
                    state_nx = TR_FIRED;
                    fire     = 1'b1;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            TR_FIRED: begin
                cnt_nx = '0;
                if (!qual) state_nx = TR_WAIT;
            end
            default: begin
                state_nx = TR_WAIT;
                cnt_nx   = '0;
            end
        endcase
    end

    // R9
    trail_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    // R9
    trail_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (level != '0));

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import fifo_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] set_vec,
    input  logic             clr_en,
    input  logic [STS_W-1:0] clr_mask,
    input  logic [STS_W-1:0] irq_en,
    output logic [STS_W-1:0] status,
    output logic             irq
);

    logic [STS_W-1:0] clr_eff;

    assign clr_eff = clr_en ? clr_mask : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_eff) | set_vec;
    end

    assign irq = |(status & irq_en);

    // R10
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((status & $past(clr_mask & ~set_vec)) == '0));
    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/fifo_irq_hub.sv
module fifo_irq_hub
    import fifo_irq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        fifo_ctl,
    input  logic [LIMIT_W-1:0] trail_limit,
    input  logic [STS_W-1:0]   irq_en,
    input  logic               tx_wr_en,
    input  logic [DW-1:0]      tx_wr_data,
    input  logic               tx_rd_en,
    output logic [DW-1:0]      tx_rd_data,
    input  logic               rx_wr_en,
    input  logic [DW-1:0]      rx_wr_data,
    input  logic               rx_rd_en,
    output logic [DW-1:0]      rx_rd_data,
    input  logic [EVT_W-1:0]   xfer_evt,
    input  logic               sts_clr_en,
    input  logic [STS_W-1:0]   sts_clr_mask,
    output logic [STS_W-1:0]   irq_status,
    output logic [31:0]        fifo_status,
    output logic               irq
);

    logic              rx_on, tx_on;
    logic [TRIG_W-1:0] rx_trig, tx_trig;
    logic [LW-1:0]     tx_lvl, rx_lvl;
    logic              tx_full, tx_empty, tx_ovr, tx_udr;
    logic              rx_full, rx_empty, rx_ovr, rx_udr;
    logic              tx_low, rx_high, trail_fire;
    logic [STS_W-1:0]  set_vec;
    logic [7:0]        tx_lvl_x, rx_lvl_x;

    assign rx_on   = fifo_ctl[CTL_RX_ON];
    assign tx_on   = fifo_ctl[CTL_TX_ON];
    assign rx_trig = fifo_ctl[CTL_RX_TRIG_L +: TRIG_W];
    assign tx_trig = fifo_ctl[CTL_TX_TRIG_L +: TRIG_W];

    byte_queue #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk(clk), .rst_n(rst_n), .enable(tx_on),
        .push(tx_wr_en), .push_data(tx_wr_data),
        .pop(tx_rd_en), .pop_data(tx_rd_data),
        .level(tx_lvl), .full(tx_full), .empty(tx_empty),
        .overrun(tx_ovr), .underrun(tx_udr)
    );

    byte_queue #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .enable(rx_on),
        .push(rx_wr_en), .push_data(rx_wr_data),
        .pop(rx_rd_en), .pop_data(rx_rd_data),
        .level(rx_lvl), .full(rx_full), .empty(rx_empty),
        .overrun(rx_ovr), .underrun(rx_udr)
    );

    trail_timer #(.LW(LW)) u_trail (
        .clk(clk), .rst_n(rst_n), .enable(rx_on),
        .level(rx_lvl), .trig(rx_trig),
        .activity(rx_wr_en || rx_rd_en),
        .limit(trail_limit), .fire(trail_fire)
    );

    assign tx_lvl_x = 8'(tx_lvl);
    assign rx_lvl_x = 8'(rx_lvl);
    assign tx_low   = tx_on && (tx_lvl_x <= 8'(tx_trig));
    assign rx_high  = rx_on && (rx_lvl_x >= 8'(rx_trig));

    always_comb begin
        set_vec              = '0;
        set_vec[ST_TX_LOW]   = tx_low;
        set_vec[ST_RX_HIGH]  = rx_high;
        set_vec[ST_TX_UNDER] = tx_udr;
        set_vec[ST_TX_OVER]  = tx_ovr;
        set_vec[ST_RX_UNDER] = rx_udr;
        set_vec[ST_RX_OVER]  = rx_ovr;
        set_vec[ST_TRAIL]    = trail_fire;
        set_vec[ST_EVT_LSB +: EVT_W] = xfer_evt;
    end

    irq_status_reg u_sts (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .clr_en(sts_clr_en), .clr_mask(sts_clr_mask),
        .irq_en(irq_en), .status(irq_status), .irq(irq)
    );

    always_comb begin
        fifo_status                          = '0;
        fifo_status[FS_TX_LVL_L +: TRIG_W]   = TRIG_W'(tx_lvl);
        fifo_status[FS_TX_FULL]              = tx_full;
        fifo_status[FS_TX_EMPTY]             = tx_empty;
        fifo_status[FS_RX_LVL_L +: TRIG_W]   = TRIG_W'(rx_lvl);
        fifo_status[FS_RX_FULL]              = rx_full;
        fifo_status[FS_RX_EMPTY]             = rx_empty;
    end

    // R3
    tx_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_status[FS_TX_FULL] && fifo_status[FS_TX_EMPTY]));
    // R12
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status == '0) |-> !irq);
    // R11
    evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|xfer_evt) |=> ((irq_status[ST_EVT_LSB +: EVT_W] & $past(xfer_evt)) == $past(xfer_evt)));

endmodule

// File: tb/tb_fifo_irq_hub.sv
module tb_fifo_irq_hub;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fifo_ctl = '0;
    logic [3:0]  trail_limit = '0;
    logic [11:0] irq_en = '0;
    logic        tx_wr_en = 1'b0, tx_rd_en = 1'b0, rx_wr_en = 1'b0, rx_rd_en = 1'b0;
    logic [7:0]  tx_wr_data = '0, rx_wr_data = '0;
    logic [7:0]  tx_rd_data, rx_rd_data;
    logic [4:0]  xfer_evt = '0;
    logic        sts_clr_en = 1'b0;
    logic [11:0] sts_clr_mask = '0;
    logic [11:0] irq_status;
    logic [31:0] fifo_status;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    logic [7:0] exp_tx, exp_rx;
    logic [11:0] snap;

    always #10 clk = ~clk;

    fifo_irq_hub #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .fifo_ctl(fifo_ctl), .trail_limit(trail_limit),
        .irq_en(irq_en), .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
        .tx_rd_en(tx_rd_en), .tx_rd_data(tx_rd_data), .rx_wr_en(rx_wr_en),
        .rx_wr_data(rx_wr_data), .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
        .xfer_evt(xfer_evt), .sts_clr_en(sts_clr_en), .sts_clr_mask(sts_clr_mask),
        .irq_status(irq_status), .fifo_status(fifo_status), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitors: compare popped bytes against the expected queues
    always @(posedge clk) begin
        if (rst_n && tx_rd_en && txq.size() > 0) begin
            exp_tx = txq.pop_front();
            #5;
            chk("R2 tx order", 32'(tx_rd_data), 32'(exp_tx));
        end
    end

    always @(posedge clk) begin
        if (rst_n && rx_rd_en && rxq.size() > 0) begin
            exp_rx = rxq.pop_front();
            #5;
            chk("R2 rx order", 32'(rx_rd_data), 32'(exp_rx));
        end
    end

    // drivers
    task automatic tx_push(input logic [7:0] b);
        @(negedge clk);
        tx_wr_en = 1'b1; tx_wr_data = b;
        if (txq.size() < DEPTH) txq.push_back(b);
        @(negedge clk);
        tx_wr_en = 1'b0;
    endtask

    task automatic tx_pop();
        @(negedge clk); tx_rd_en = 1'b1;
        @(negedge clk); tx_rd_en = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        rx_wr_en = 1'b1; rx_wr_data = b;
        if (rxq.size() < DEPTH) rxq.push_back(b);
        @(negedge clk);
        rx_wr_en = 1'b0;
    endtask

    task automatic rx_pop();
        @(negedge clk); rx_rd_en = 1'b1;
        @(negedge clk); rx_rd_en = 1'b0;
    endtask

    task automatic clr(input logic [11:0] m);
        @(negedge clk); sts_clr_en = 1'b1; sts_clr_mask = m;
        @(negedge clk); sts_clr_en = 1'b0; sts_clr_mask = '0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R3 layout of empty flags
        chk("R1 status", 32'(irq_status), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 R3 fifo_status", fifo_status, 32'h0100_0100);
        chk("R1 rd_data", 32'({tx_rd_data, rx_rd_data}), 0);

        // enable both: rx trig 4, tx trig 2, trailing limit 3
        trail_limit = 4'd3;
        fifo_ctl = 32'h3 | (32'd4 << 4) | (32'd2 << 16);
        @(negedge clk);
        chk("R7 tx low at level 0", 32'(irq_status[0]), 1);
        clr(12'h001);
        chk("R10 set wins over clear", 32'(irq_status[0]), 1);

        for (int i = 0; i < 5; i++) tx_push(8'hA0 + 8'(i));
        clr(12'h001);
        chk("R7 tx low clear above trig", 32'(irq_status[0]), 0);
        chk("R3 tx level", 32'(fifo_status[8:0]), 32'd5);

        for (int i = 0; i < 3; i++) tx_pop();
        @(negedge clk);
        chk("R7 tx low at level 2", 32'(irq_status[0]), 1);

        for (int i = 0; i < 2; i++) tx_pop();
        tx_pop();
        chk("R5 tx underrun flag", 32'(irq_status[2]), 1);
        chk("R5 tx data kept", 32'(tx_rd_data), 32'h A4);

        // R4 fill then overflow
        for (int i = 0; i < DEPTH; i++) tx_push(8'h10 + 8'(i));
        chk("R3 tx full flag", 32'(fifo_status[8:0]), 32'h090);
        tx_push(8'hFF);
        chk("R4 tx overrun flag", 32'(irq_status[3]), 1);
        chk("R4 tx level held", 32'(fifo_status[6:0]), DEPTH);
        for (int i = 0; i < DEPTH; i++) tx_pop();
        chk("R4 dropped byte absent", 32'(tx_rd_data), 32'h1F);
        chk("R2 tx queue drained", 32'(txq.size()), 0);

        // R9 trailing: 3 bytes below trig 4, limit 3
        rx_push(8'h50); rx_push(8'h51); rx_push(8'h52);
        repeat (3) @(negedge clk);
        chk("R9 trailing not yet", 32'(irq_status[6]), 0);
        @(negedge clk);
        chk("R9 trailing fires", 32'(irq_status[6]), 1);
        clr(12'h040);
        chk("R10 trailing cleared", 32'(irq_status[6]), 0);
        repeat (4) @(negedge clk);
        chk("R9 once per stretch", 32'(irq_status[6]), 0);

        // R8 high watermark
        clr(12'h002);
        rx_push(8'h53);
        @(negedge clk);
        chk("R8 rx high at trig", 32'(irq_status[1]), 1);
        chk("R3 rx level", 32'(fifo_status[24:16]), 32'd4);
        for (int i = 0; i < 4; i++) rx_pop();
        rx_pop();
        chk("R5 rx underrun flag", 32'(irq_status[4]), 1);
        chk("R5 rx data kept", 32'(rx_rd_data), 32'h53);

        for (int i = 0; i <= DEPTH; i++) rx_push(8'h60 + 8'(i));
        chk("R4 rx overrun flag", 32'(irq_status[5]), 1);
        chk("R4 R3 rx full level", 32'(fifo_status[24:16]), 32'h090);

        // R6 disable receive side
        @(negedge clk);
        fifo_ctl[0] = 1'b0;
        rxq.delete();
        @(negedge clk);
        chk("R6 rx flushed", 32'(fifo_status[24:16]), 32'h100);
        clr(12'h030);
        @(negedge clk);
        rx_wr_en = 1'b1; rx_wr_data = 8'h77;
        @(negedge clk);
        rx_wr_en = 1'b0;
        chk("R6 no overrun while off", 32'(irq_status[5:4]), 0);
        chk("R6 push ignored while off", 32'(fifo_status[22:16]), 0);
        fifo_ctl[0] = 1'b1;
        @(negedge clk);
        chk("R6 still empty after re-enable", 32'(fifo_status[24:16]), 32'h100);

        // R11 transfer events
        clr(12'hF80);
        @(negedge clk); xfer_evt = 5'b10101;
        @(negedge clk); xfer_evt = '0;
        chk("R11 event bits", 32'(irq_status[11:7]), 32'b10101);

        // R12 interrupt gating
        irq_en = 12'h200; #1;
        chk("R12 irq enabled bit", 32'(irq), 1);
        irq_en = 12'h100; #1;
        chk("R12 irq masked bit", 32'(irq), 0);

        // R10 write back everything read
        fifo_ctl = '0;
        irq_en = 12'hFFF;
        @(negedge clk); @(negedge clk);
        snap = irq_status;
        clr(snap);
        chk("R10 write-back clears all", 32'(irq_status), 0);
        chk("R12 irq low when clear", 32'(irq), 0);

        finish_run();
    end

endmodule